// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Pin Configuration

This block is a memory-mapped general-purpose I/O controller for 94 pins. Software reaches it through a simple single-cycle register bus. Three kinds of bitmapped words each cover 32 pins: pin ownership, interrupt status and interrupt enable. Each pin also has a pair of configuration words. These hold the driven level, the direction, the choice between the native function and GPIO use, the trigger type, an input-sense gate and a stored weak-pull code. The sampled input level can be read back from the first configuration word.

Every pin input passes through a two-flop synchronizer. The controller then looks for the configured event: rising edge, falling edge, low level or high level. An event sets that pin's sticky status bit, and software clears status bits by writing ones to them. A status bit that is also enabled raises the combined interrupt. A routing register selects which of two interrupt lines carries it.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every enable bit and every status bit is 0, and the interrupt outputs are low. Ownership bits of the implemented pins are 1. Each pin's first config word reads 0x00000005, which means GPIO use and input direction. Each second config word reads 0x00000004, which means sensing is disabled.
- R2: Pin n sits at bit n%32 of bitmapped word n/32. Word w of the ownership, status and enable words is at byte address 0x00+4w, 0x80+4w and 0x90+4w. The ownership and enable words are read/write. Bits for pin numbers 94 and 95 read 0.
- R3: The first config word of pin n is at 0x100+8n. Its writable fields are bit 31 (drive level), bit 4 (trigger select), bit 3 (trigger invert), bit 2 (direction, 1 = input) and bit 0 (use, 1 = GPIO). Bit 30 is read-only, and all other bits read 0.
- R4: pin_out[n] follows bit 31 of the pin's first config word. pin_oe[n] is 1 only when the use bit is 1 and the direction bit is 0.
- R5: The pair {bit 4, bit 3} picks the event: 00 = rising edge, 01 = falling edge, 10 = low level, 11 = high level.
- R6: The input passes through two flops before detection. When sensing is enabled, bit 30 reads that synchronized level; when sensing is disabled, bit 30 reads 0.
- R7: A status bit sets only while the pin has sensing enabled, the use bit at 1 and the direction bit at 1. With sensing disabled or with output direction, input edges leave status at 0.
- R8: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. If an event arrives in the same cycle as the clear, the event wins and the bit stays set.
- R9: While a level trigger's active level persists, the status bit sets again on every cycle, so a clear does not stick.
- R10: A pending interrupt exists when some status bit and its enable bit are both 1. Bit 0 of the routing register at 0x7C sends it to irq_o[0] (value 0) or to irq_o[1] (value 1). Only the selected line is driven, and an enabled bit of 0 masks its status bit.
- R11: Read data appears on bus_rdata in the cycle after the read request, and is 0 in cycles that follow no read. Reads of unimplemented addresses return 0. This includes 0x8C, 0x9C, any gap in the map, and config addresses past the last pin.
- R12: The second config word of pin n is at 0x104+8n. Bit 2 disables sensing, and bits 1:0 store a pull code that has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after a read request |
| pin_in | input | 94 | Asynchronous pin input levels |
| pin_out | output | 94 | Driven pin levels |
| pin_oe | output | 94 | Pin output enables |
| irq_o | output | 2 | Combined interrupt, on the routed line |

## Verification
The assertions take three things for granted. Bus addresses are word aligned. A pin input holds its level for at least one full clock after a change, so the two-stage delay from pin to event can be checked against the pin value two cycles earlier. The bus carries no unknown values once reset is released. The stimulus keeps within these limits in the following way. It changes pin levels and bus signals only on the falling clock edge. It holds each pin level for several cycles before it reads status. It always turns sensing on last, after the trigger type is set, so that no reconfiguration can produce an edge that nobody expects.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    localparam int OWN_BASE   = 'h000;
    localparam int ROUTE_ADDR = 'h07C;
    localparam int STAT_BASE  = 'h080;
    localparam int EN_BASE    = 'h090;
    localparam int CFG_BASE   = 'h100;
    localparam int CFG_STRIDE = 8;
    localparam int WORD_BITS  = 32;

    localparam int C1_OUT  = 31;
    localparam int C1_IN   = 30;
    localparam int C1_TSEL = 4;
    localparam int C1_TINV = 3;
    localparam int C1_DIR  = 2;
    localparam int C1_USE  = 0;
    localparam int C2_SDIS = 2;

    typedef enum logic [2:0] {
        RG_NONE, RG_OWN, RG_ROUTE, RG_STAT, RG_EN, RG_CFG1, RG_CFG2
    } region_t;

    typedef struct packed {
        logic       out_lvl;
        logic       trig_lvl;
        logic       trig_inv;
        logic       dir_in;
        logic       use_gpio;
        logic       sense_dis;
        logic [1:0] pull;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{out_lvl: 1'b0, trig_lvl: 1'b0, trig_inv: 1'b0,
                                       dir_in: 1'b1, use_gpio: 1'b1, sense_dis: 1'b1,
                                       pull: 2'b00};

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_PINS  = 94,
    parameter int NUM_WORDS = 3,
    parameter int PIDX_W    = 7,
    parameter int WIDX_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region,
    output logic [WIDX_W-1:0] widx,
    output logic [PIDX_W-1:0] pidx
);
    localparam logic [ADDR_W-1:0] A_OWN   = ADDR_W'(OWN_BASE);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(STAT_BASE);
    localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(EN_BASE);
    localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(ROUTE_ADDR);
    localparam logic [ADDR_W-1:0] BM_SPAN  = ADDR_W'(4 * NUM_WORDS);
    localparam logic [ADDR_W-1:0] CFG_SPAN = ADDR_W'(CFG_STRIDE * NUM_PINS);

    logic [ADDR_W-1:0] off_own, off_stat, off_en, off_cfg;

    always_comb begin
        off_own  = addr - A_OWN;
        off_stat = addr - A_STAT;
        off_en   = addr - A_EN;
        off_cfg  = addr - A_CFG;
        region   = RG_NONE;
        widx     = '0;
        pidx     = '0;
        if (off_own < BM_SPAN) begin
            region = RG_OWN;
            widx   = off_own[WIDX_W+1:2];
        end else if (addr == A_ROUTE) begin
            region = RG_ROUTE;
        end else if (off_stat < BM_SPAN) begin
            region = RG_STAT;
            widx   = off_stat[WIDX_W+1:2];
        end else if (off_en < BM_SPAN) begin
            region = RG_EN;
            widx   = off_en[WIDX_W+1:2];
        end else if (off_cfg < CFG_SPAN) begin
            region = off_cfg[2] ? RG_CFG2 : RG_CFG1;
            pidx   = off_cfg[PIDX_W+2:3];
        end
    end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pin_in,
    input  logic        wr_cfg1,
    input  logic        wr_cfg2,
    input  logic [31:0] wdata,
    output logic [31:0] cfg1_rd,
    output logic [31:0] cfg2_rd,
    output logic        pin_out,
    output logic        pin_oe,
    output logic        evt_o
);
    typedef struct packed {
        pin_cfg_t               cfg;
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } cell_state_t;

    cell_state_t state_d, state_q;
    logic lvl, armed;

    assign lvl   = state_q.sync[SYNC_STAGES-1];
    assign armed = !state_q.cfg.sense_dis && state_q.cfg.use_gpio && state_q.cfg.dir_in;

    always_comb begin
        state_d      = state_q;
        state_d.sync = {state_q.sync[SYNC_STAGES-2:0], pin_in};
        state_d.prev = lvl;
        if (wr_cfg1) begin
            state_d.cfg.out_lvl  = wdata[C1_OUT];
            state_d.cfg.trig_lvl = wdata[C1_TSEL];
            state_d.cfg.trig_inv = wdata[C1_TINV];
            state_d.cfg.dir_in   = wdata[C1_DIR];
            state_d.cfg.use_gpio = wdata[C1_USE];
        end
        if (wr_cfg2) begin
            state_d.cfg.sense_dis = wdata[C2_SDIS];
            state_d.cfg.pull      = wdata[1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{cfg: CFG_RESET, sync: '0, prev: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case ({state_q.cfg.trig_lvl, state_q.cfg.trig_inv})
            2'b00:   evt_o = armed && lvl && !state_q.prev;
            2'b01:   evt_o = armed && !lvl && state_q.prev;
            2'b10:   evt_o = armed && !lvl;
            default: evt_o = armed && lvl;
        endcase
    end

    always_comb begin
        cfg1_rd          = '0;
        cfg1_rd[C1_OUT]  = state_q.cfg.out_lvl;
        cfg1_rd[C1_IN]   = lvl && !state_q.cfg.sense_dis;
        cfg1_rd[C1_TSEL] = state_q.cfg.trig_lvl;
        cfg1_rd[C1_TINV] = state_q.cfg.trig_inv;
        cfg1_rd[C1_DIR]  = state_q.cfg.dir_in;
        cfg1_rd[C1_USE]  = state_q.cfg.use_gpio;
        cfg2_rd          = '0;
        cfg2_rd[C2_SDIS] = state_q.cfg.sense_dis;
        cfg2_rd[1:0]     = state_q.cfg.pull;
    end

    assign pin_out = state_q.cfg.out_lvl;
    assign pin_oe  = state_q.cfg.use_gpio && !state_q.cfg.dir_in;

    // A rising-edge event must trace back to a high pin two flops earlier.
    assert_rise_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && !state_q.cfg.trig_lvl && !state_q.cfg.trig_inv) |-> $past(pin_in, 2));

    // A falling-edge event must trace back to a low pin two flops earlier.
    assert_fall_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && !state_q.cfg.trig_lvl && state_q.cfg.trig_inv) |-> !$past(pin_in, 2));
endmodule

// File: rtl/gpio_bitmap_regs.sv
module gpio_bitmap_regs
    import gpio_ctrl_pkg::*;
#(
    parameter int                  NUM_PINS  = 94,
    parameter int                  NUM_WORDS = 3,
    parameter int                  WIDX_W    = 2,
    parameter logic [NUM_PINS-1:0] OWN_RESET = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] evt,
    input  logic                wr_own,
    input  logic                wr_stat,
    input  logic                wr_en,
    input  logic [WIDX_W-1:0]   widx,
    input  logic [31:0]         wdata,
    output logic [NUM_PINS-1:0] own_vec,
    output logic [NUM_PINS-1:0] stat_vec,
    output logic [NUM_PINS-1:0] en_vec
);
    typedef struct packed {
        logic [NUM_PINS-1:0] own;
        logic [NUM_PINS-1:0] stat;
        logic [NUM_PINS-1:0] en;
    } bm_state_t;

    bm_state_t state_d, state_q;
    logic [NUM_PINS-1:0] clr;

    always_comb begin
        state_d = state_q;
        clr     = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (widx == WIDX_W'(p / WORD_BITS)) begin
                if (wr_own) state_d.own[p] = wdata[p % WORD_BITS];
                if (wr_en)  state_d.en[p]  = wdata[p % WORD_BITS];
                if (wr_stat) clr[p] = wdata[p % WORD_BITS];
            end
        end
        state_d.stat = (state_q.stat & ~clr) | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{own: OWN_RESET, stat: '0, en: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign own_vec  = state_q.own;
    assign stat_vec = state_q.stat;
    assign en_vec   = state_q.en;

    // A one-to-clear with no competing event leaves the bit at 0.
    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~evt)) |=> ((state_q.stat & $past(clr & ~evt)) == '0));

    // Every event lands in status on the next cycle, clear or not.
    assert_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((state_q.stat & $past(evt)) == $past(evt)));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int NUM_PINS    = 94,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [1:0]          irq_o
);
    localparam int NUM_WORDS = (NUM_PINS + WORD_BITS - 1) / WORD_BITS;
    localparam int PAD_W     = NUM_WORDS * WORD_BITS;
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int PIDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    region_t           region;
    logic [WIDX_W-1:0] widx;
    logic [PIDX_W-1:0] pidx;
    logic              wr, rd;

    assign wr = bus_sel && bus_wr;
    assign rd = bus_sel && !bus_wr;

    gpio_bus_decode #(
        .ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS), .NUM_WORDS(NUM_WORDS),
        .PIDX_W(PIDX_W), .WIDX_W(WIDX_W)
    ) u_decode (
        .addr(bus_addr), .region(region), .widx(widx), .pidx(pidx)
    );

    logic [NUM_PINS-1:0] evt, own_vec, stat_vec, en_vec;

    gpio_bitmap_regs #(
        .NUM_PINS(NUM_PINS), .NUM_WORDS(NUM_WORDS), .WIDX_W(WIDX_W),
        .OWN_RESET({NUM_PINS{1'b1}})
    ) u_bitmap (
        .clk(clk), .rst_n(rst_n), .evt(evt),
        .wr_own(wr && region == RG_OWN),
        .wr_stat(wr && region == RG_STAT),
        .wr_en(wr && region == RG_EN),
        .widx(widx), .wdata(bus_wdata),
        .own_vec(own_vec), .stat_vec(stat_vec), .en_vec(en_vec)
    );

    logic [31:0] cfg1_arr [NUM_PINS];
    logic [31:0] cfg2_arr [NUM_PINS];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpio_pin_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
            .clk(clk), .rst_n(rst_n), .pin_in(pin_in[p]),
            .wr_cfg1(wr && region == RG_CFG1 && pidx == PIDX_W'(p)),
            .wr_cfg2(wr && region == RG_CFG2 && pidx == PIDX_W'(p)),
            .wdata(bus_wdata),
            .cfg1_rd(cfg1_arr[p]), .cfg2_rd(cfg2_arr[p]),
            .pin_out(pin_out[p]), .pin_oe(pin_oe[p]), .evt_o(evt[p])
        );
    end

    typedef struct packed {
        logic        route;
        logic [31:0] rdata;
    } top_state_t;

    top_state_t state_d, state_q;
    logic [PAD_W-1:0] own_pad, stat_pad, en_pad;
    logic [31:0]      rd_val;
    logic             pending;

    assign own_pad  = PAD_W'(own_vec);
    assign stat_pad = PAD_W'(stat_vec);
    assign en_pad   = PAD_W'(en_vec);

    always_comb begin
        unique case (region)
            RG_OWN:   rd_val = own_pad[widx*WORD_BITS +: WORD_BITS];
            RG_STAT:  rd_val = stat_pad[widx*WORD_BITS +: WORD_BITS];
            RG_EN:    rd_val = en_pad[widx*WORD_BITS +: WORD_BITS];
            RG_ROUTE: rd_val = {31'b0, state_q.route};
            RG_CFG1:  rd_val = cfg1_arr[pidx];
            RG_CFG2:  rd_val = cfg2_arr[pidx];
            default:  rd_val = '0;
        endcase
    end

    always_comb begin
        state_d       = state_q;
        state_d.rdata = rd ? rd_val : '0;
        if (wr && region == RG_ROUTE) state_d.route = bus_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{route: 1'b0, rdata: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign pending   = |(stat_vec & en_vec);
    assign irq_o     = {pending && state_q.route, pending && !state_q.route};
    assign bus_rdata = state_q.rdata;

    // Never both lines at once.
    assert_irq_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));

    // A raised line needs an enabled, latched status bit.
    assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> (|(stat_vec & en_vec)));

    // Read data is zero in any cycle that follows no read request.
    assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> (bus_rdata == 32'h0));
endmodule

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
    localparam int NP = 94;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic [1:0]    irq_o;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic rd_vld = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    gpio_bank_ctrl u_gpio_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_vld <= rst_n && bus_sel && !bus_wr;

    // Monitor: pops one expectation for each returned read.
    always @(negedge clk) begin
        if (rd_vld && exp_q.size() > 0) begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        bus_read(12'h090, 32'h0, "R1 enable word0");
        bus_read(12'h080, 32'h0, "R1 status word0");
        bus_read(12'h000, 32'hFFFF_FFFF, "R1 ownership word0");
        bus_read(12'h100, 32'h0000_0005, "R1 cfg1 pin0");
        bus_read(12'h104, 32'h0000_0004, "R1 cfg2 pin0");
        check("R1 irq idle", {30'b0, irq_o}, 32'h0);
        // R2 top word padding
        bus_read(12'h008, 32'h3FFF_FFFF, "R2 ownership word2 pad");
        // R4 drive and enable
        bus_write(12'h128, 32'h8000_0001);
        check("R4 pin_out5", {31'b0, pin_out[5]}, 32'h1);
        check("R4 pin_oe5 gpio output", {31'b0, pin_oe[5]}, 32'h1);
        bus_write(12'h128, 32'h8000_0000);
        check("R4 pin_oe5 native", {31'b0, pin_oe[5]}, 32'h0);
        // R3 writable fields, R12 pull storage
        bus_write(12'h140, 32'hFFFF_FFFF);
        bus_read(12'h140, 32'h8000_001D, "R3 cfg1 pin8 field mask");
        bus_write(12'h13C, 32'h0000_0003);
        bus_read(12'h13C, 32'h0000_0003, "R12 cfg2 pin7 pull stored");
        check("R12 pull no output effect", {30'b0, pin_oe[7], pin_out[7]}, 32'h0);
        // R6 rising edge on pin3
        bus_write(12'h11C, 32'h0);
        bus_write(12'h090, 32'h0000_0008);
        pin_in[3] = 1'b1;
        idle(4);
        bus_read(12'h080, 32'h0000_0008, "R6 rising pin3 status");
        check("R10 irq line0", {30'b0, irq_o}, 32'h1);
        bus_read(12'h118, 32'h4000_0005, "R6 input level visible");
        // R8 clear
        bus_write(12'h080, 32'h0000_0008);
        bus_read(12'h080, 32'h0, "R8 w1c status");
        check("R8 irq after clear", {30'b0, irq_o}, 32'h0);
        // R7 output direction and disabled sense
        bus_write(12'h1A8, 32'h0000_0001);
        bus_write(12'h1AC, 32'h0);
        pin_in[21] = 1'b1;
        pin_in[20] = 1'b1;
        idle(4);
        bus_read(12'h080, 32'h0, "R7 no latch output/sense-off");
        bus_read(12'h1A0, 32'h0000_0005, "R6 level hidden when sense off");
        // R5 falling edge pin40 (word1 bit8)
        bus_write(12'h240, 32'h0000_000D);
        bus_write(12'h244, 32'h0);
        pin_in[40] = 1'b1;
        idle(4);
        bus_read(12'h084, 32'h0, "R5 falling ignores rise");
        pin_in[40] = 1'b0;
        idle(4);
        bus_read(12'h084, 32'h0000_0100, "R5 falling pin40");
        check("R10 masked by enable", {30'b0, irq_o}, 32'h0);
        bus_write(12'h07C, 32'h1);
        bus_write(12'h094, 32'h0000_0100);
        check("R10 routed to line1", {30'b0, irq_o}, 32'h2);
        bus_read(12'h07C, 32'h1, "R10 route readback");
        bus_write(12'h084, 32'hFFFF_FFFF);
        bus_read(12'h084, 32'h0, "R8 full-word clear");
        bus_write(12'h07C, 32'h0);
        // R9 level high pin70 (word2 bit6)
        pin_in[70] = 1'b1;
        bus_write(12'h330, 32'h0000_001D);
        bus_write(12'h334, 32'h0);
        idle(4);
        bus_write(12'h088, 32'hFFFF_FFFF);
        bus_read(12'h088, 32'h0000_0040, "R9 level re-asserts");
        pin_in[70] = 1'b0;
        idle(4);
        bus_write(12'h088, 32'hFFFF_FFFF);
        bus_read(12'h088, 32'h0, "R9 cleared once inactive");
        // R5 level low pin10
        bus_write(12'h150, 32'h0000_0015);
        bus_write(12'h154, 32'h0);
        idle(4);
        bus_read(12'h080, 32'h0000_0400, "R5 level low pin10");
        bus_write(12'h154, 32'h0000_0004);
        bus_write(12'h080, 32'hFFFF_FFFF);
        bus_read(12'h080, 32'h0, "R7 sense off stops level");
        // R2 bitmap writes
        bus_write(12'h098, 32'hFFFF_FFFF);
        bus_read(12'h098, 32'h3FFF_FFFF, "R2 enable word2 pad");
        bus_write(12'h000, 32'h0);
        bus_read(12'h000, 32'h0, "R2 ownership word0 write");
        bus_read(12'h004, 32'hFFFF_FFFF, "R2 ownership word1 kept");
        // R11 unimplemented
        bus_read(12'h08C, 32'h0, "R11 gap 0x8C");
        bus_read(12'h040, 32'h0, "R11 gap 0x40");
        bus_read(12'h3F0, 32'h0, "R11 past last pin");
        bus_read(12'h3EC, 32'h0000_0004, "R11 last pin cfg2");
        idle(3);
        check("R11 queue drained", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule